// File: doc/BRIEF.md
# Unified-Index Physical Register File

This block is the physical register store of an out-of-order core. An integer bank and a floating-point bank live behind a single physical index space. Indices from zero up to the integer bank size address integer entries. The floating-point entries sit directly above them, so a floating-point access subtracts the integer bank size from the index to find its entry. Two combinational read ports and one write port each carry a physical index. Floating-point entries hold raw 64-bit patterns, and the block does no arithmetic on them.

Both banks protect a fixed architectural zero slot, and the check uses the bank-relative index. An integer write to that slot is always dropped. A floating-point write is dropped on the same relative slot unless the write port's raw flag is set. With the raw flag set, the bits are stored unconditionally. An index beyond both banks raises an error output. A read at such an index returns zero, and a write at such an index is dropped. The asynchronous reset is released synchronously inside the block and clears every entry.

Top module: `unified_prf`

## Requirements
- R1: A physical index below NUM_INT (default 64) reads and writes integer entry number equal to the index, up to and including index NUM_INT-1.
- R2: An index from NUM_INT to NUM_INT+NUM_FP-1 (default 64..127) addresses floating-point entry index-NUM_INT. A write to one bank never changes the other bank.
- R3: An integer write whose index equals ZERO_IDX (default 31) is dropped, whatever the value of wr_raw, and the entry stays zero.
- R4: A floating-point write with wr_raw=0 whose bank-relative index equals ZERO_IDX (physical NUM_INT+ZERO_IDX, default 95) is dropped.
- R5: A floating-point write with wr_raw=1 always updates its entry, including the entry at relative slot ZERO_IDX.
- R6: After reset every entry in both banks reads as zero, and idx_err is low while all indices are in range.
- R7: Reads are combinational. A write becomes visible on reads only after the clock edge that accepts it, and a read of the same index earlier in that cycle returns the old value.
- R8: The two read ports are independent and may read the same entry or different entries at the same time.
- R9: An index at or above NUM_INT+NUM_FP on either read port, or on the write port while wr_en=1, drives idx_err high. Such a read returns zero, and such a write changes no entry.
- R10: With wr_en=0 no entry changes, and wr_idx does not affect idx_err.
- R11: A floating-point entry returns all 64 bits exactly as written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write request |
| wr_raw | input | 1 | 1 stores floating-point bits without the zero-slot check |
| wr_idx | input | IDX_W | Physical write index |
| wr_data | input | DATA_W | Write data |
| rd_a_idx | input | IDX_W | Physical index, read port A |
| rd_a_data | output | DATA_W | Read data, port A |
| rd_b_idx | input | IDX_W | Physical index, read port B |
| rd_b_data | output | DATA_W | Read data, port B |
| idx_err | output | 1 | Some active index lies outside both banks |

## Verification
The hardest situation to produce is the floating-point zero slot. Whether it is written depends on the raw flag, so reaching it from the ports needs a sequence on the same physical index. The stimulus first issues a value write there and confirms it was dropped. It then issues a raw write of a full-width pattern and confirms the pattern was stored. Finally it issues another value write and confirms that the stored pattern survives. Out-of-range writes are checked at the index that the truncated address would alias to, which shows that storage outside the chosen entry is untouched.

// File: rtl/urf_pkg.sv
package urf_pkg;
  typedef enum logic [1:0] {
    SEL_INT  = 2'd0,
    SEL_FP   = 2'd1,
    SEL_NONE = 2'd2
  } urf_sel_e;
endpackage

// File: rtl/urf_rst_sync.sv
module urf_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_sync_n <= stage_q;
    end
  end
endmodule

// File: rtl/urf_decode.sv
module urf_decode
  import urf_pkg::*;
#(
  parameter int NUM_INT = 64,
  parameter int NUM_FP  = 64,
  parameter int IDX_W   = 8
) (
  input  logic [IDX_W-1:0] idx,
  output urf_sel_e         sel,
  output logic [IDX_W-1:0] off
);
  localparam logic [IDX_W:0]   INT_LIM  = (IDX_W+1)'(NUM_INT);
  localparam logic [IDX_W:0]   TOT_LIM  = (IDX_W+1)'(NUM_INT + NUM_FP);
  localparam logic [IDX_W-1:0] FP_BASE  = IDX_W'(NUM_INT);

  always_comb begin
    if ({1'b0, idx} < INT_LIM) begin
      sel = SEL_INT;
      off = idx;
    end else if ({1'b0, idx} < TOT_LIM) begin
      sel = SEL_FP;
      off = idx - FP_BASE;
    end else begin
      sel = SEL_NONE;
      off = '0;
    end
  end
endmodule

// File: rtl/urf_bank.sv
module urf_bank #(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 64,
  parameter int AW     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     ra_addr,
  output logic [DATA_W-1:0] ra_data,
  input  logic [AW-1:0]     rb_addr,
  output logic [DATA_W-1:0] rb_data
);
  logic [DATA_W-1:0] mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    logic              en;
    logic [DATA_W-1:0] q;

    assign en = we && (waddr == AW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= '0;
      end else if (en) begin
        q <= wdata;
      end
    end

    assign mem[g] = q;
  end

  always_comb begin
    ra_data = '0;
    rb_data = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (ra_addr == AW'(i)) ra_data = mem[i];
      if (rb_addr == AW'(i)) rb_data = mem[i];
    end
  end

  AST_WRITE_NEXT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (we && ra_addr == waddr) |=> ($stable(ra_addr) -> ra_data == $past(wdata))); // R7
endmodule

// File: rtl/unified_prf.sv
module unified_prf
  import urf_pkg::*;
#(
  parameter int NUM_INT  = 64,
  parameter int NUM_FP   = 64,
  parameter int ZERO_IDX = 31,
  parameter int DATA_W   = 64,
  parameter int IDX_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_raw,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_a_idx,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [IDX_W-1:0]  rd_b_idx,
  output logic [DATA_W-1:0] rd_b_data,
  output logic              idx_err
);
  localparam logic [IDX_W-1:0] ZERO_REL = IDX_W'(ZERO_IDX);
  localparam logic [IDX_W-1:0] FP_ZERO  = IDX_W'(NUM_INT + ZERO_IDX);

  logic rst_sync_n;

  urf_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  urf_sel_e         wr_sel, ra_sel, rb_sel;
  logic [IDX_W-1:0] wr_off, ra_off, rb_off;

  urf_decode #(.NUM_INT(NUM_INT), .NUM_FP(NUM_FP), .IDX_W(IDX_W))
    u_dec_wr (.idx(wr_idx), .sel(wr_sel), .off(wr_off));
  urf_decode #(.NUM_INT(NUM_INT), .NUM_FP(NUM_FP), .IDX_W(IDX_W))
    u_dec_ra (.idx(rd_a_idx), .sel(ra_sel), .off(ra_off));
  urf_decode #(.NUM_INT(NUM_INT), .NUM_FP(NUM_FP), .IDX_W(IDX_W))
    u_dec_rb (.idx(rd_b_idx), .sel(rb_sel), .off(rb_off));

  logic int_we, fp_we;

  always_comb begin
    int_we = wr_en && (wr_sel == SEL_INT) && (wr_off != ZERO_REL);
    fp_we  = wr_en && (wr_sel == SEL_FP)  && (wr_raw || (wr_off != ZERO_REL));
  end

  logic [DATA_W-1:0] int_ra, int_rb, fp_ra, fp_rb;

  urf_bank #(.DEPTH(NUM_INT), .DATA_W(DATA_W), .AW(IDX_W)) u_int_bank (
    .clk(clk), .rst_n(rst_sync_n), .we(int_we), .waddr(wr_off), .wdata(wr_data),
    .ra_addr(ra_off), .ra_data(int_ra), .rb_addr(rb_off), .rb_data(int_rb)
  );

  urf_bank #(.DEPTH(NUM_FP), .DATA_W(DATA_W), .AW(IDX_W)) u_fp_bank (
    .clk(clk), .rst_n(rst_sync_n), .we(fp_we), .waddr(wr_off), .wdata(wr_data),
    .ra_addr(ra_off), .ra_data(fp_ra), .rb_addr(rb_off), .rb_data(fp_rb)
  );

  always_comb begin
    unique case (ra_sel)
      SEL_INT: rd_a_data = int_ra;
      SEL_FP:  rd_a_data = fp_ra;
      default: rd_a_data = '0;
    endcase
    unique case (rb_sel)
      SEL_INT: rd_b_data = int_rb;
      SEL_FP:  rd_b_data = fp_rb;
      default: rd_b_data = '0;
    endcase
  end

  always_comb begin
    idx_err = (ra_sel == SEL_NONE) || (rb_sel == SEL_NONE) ||
              (wr_en && (wr_sel == SEL_NONE));
  end

  AST_INT_ZERO_HELD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && wr_idx == ZERO_REL && rd_a_idx == ZERO_REL)
      |=> ($stable(rd_a_idx) -> rd_a_data == $past(rd_a_data))); // R3

  AST_FP_ZERO_HELD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && !wr_raw && wr_idx == FP_ZERO && rd_a_idx == FP_ZERO)
      |=> ($stable(rd_a_idx) -> rd_a_data == $past(rd_a_data))); // R4

  AST_RAW_STORES: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && wr_raw && wr_sel == SEL_FP && rd_b_idx == wr_idx)
      |=> ($stable(rd_b_idx) -> rd_b_data == $past(wr_data))); // R5

  AST_OOR_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ra_sel == SEL_NONE) |-> (rd_a_data == '0 && idx_err)); // R9

  AST_OOR_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && wr_sel == SEL_NONE) |-> (!int_we && !fp_we)); // R9

  AST_BANKS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0({int_we, fp_we})); // R2
endmodule

// File: tb/unified_prf_test.sv
module unified_prf_test;
  localparam int IDX_W  = 8;
  localparam int DATA_W = 64;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              wr_en, wr_raw;
  logic [IDX_W-1:0]  wr_idx, rd_a_idx, rd_b_idx;
  logic [DATA_W-1:0] wr_data, rd_a_data, rd_b_data;
  logic              idx_err;

  int n_checks = 0;
  int n_fail   = 0;

  always #10 clk = ~clk;

  unified_prf uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_raw(wr_raw), .wr_idx(wr_idx),
    .wr_data(wr_data), .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data), .idx_err(idx_err)
  );

  task automatic check(input string tag, input logic [DATA_W-1:0] got,
                       input logic [DATA_W-1:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic write(input int idx, input logic [DATA_W-1:0] d, input logic raw);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = IDX_W'(idx); wr_data = d; wr_raw = raw;
    @(negedge clk);
    wr_en = 1'b0; wr_raw = 1'b0; wr_idx = '0;
  endtask

  task automatic read2(input int a, input int b);
    rd_a_idx = IDX_W'(a); rd_b_idx = IDX_W'(b);
    #1;
  endtask

  task automatic t_reset();
    int bad = 0;
    for (int i = 0; i < 128; i++) begin
      read2(i, 127 - i);
      if (rd_a_data !== '0 || rd_b_data !== '0) bad++;
    end
    check("R6 entries nonzero after reset", DATA_W'(bad), '0);
    check("R6 idx_err after reset", DATA_W'(idx_err), '0);
  endtask

  task automatic t_banks();
    write(5,  64'h1111_2222_3333_4444, 1'b0);
    write(69, 64'hAAAA_BBBB_CCCC_DDDD, 1'b0);
    write(63, 64'h0000_0000_0000_0063, 1'b0);
    write(64, 64'h0000_0000_0000_0064, 1'b0);
    read2(5, 69);
    check("R1 int entry 5", rd_a_data, 64'h1111_2222_3333_4444);
    check("R2 fp entry 69", rd_b_data, 64'hAAAA_BBBB_CCCC_DDDD);
    read2(63, 64);
    check("R1 last int index 63", rd_a_data, 64'h63);
    check("R2 first fp index 64", rd_b_data, 64'h64);
    read2(69, 69);
    check("R8 port A same entry", rd_a_data, 64'hAAAA_BBBB_CCCC_DDDD);
    check("R8 port B same entry", rd_b_data, 64'hAAAA_BBBB_CCCC_DDDD);
    read2(0, 72);
    check("R2 other int entry untouched", rd_a_data, '0);
    check("R2 other fp entry untouched", rd_b_data, '0);
  endtask

  task automatic t_int_zero();
    write(31, 64'hDEAD_0000_0000_0031, 1'b0);
    write(31, 64'hDEAD_1111_0000_0031, 1'b1);
    write(30, 64'h0000_0000_0000_0030, 1'b0);
    read2(31, 30);
    check("R3 int zero slot dropped", rd_a_data, '0);
    check("R3 neighbour slot written", rd_b_data, 64'h30);
  endtask

  task automatic t_fp_zero_raw();
    write(95, 64'hBAD0_BAD0_BAD0_BAD0, 1'b0);
    read2(95, 31);
    check("R4 fp zero slot value write dropped", rd_a_data, '0);
    check("R2 int slot 31 unaffected", rd_b_data, '0);
    write(95, 64'h7FF8_0000_0000_0001, 1'b1);
    read2(95, 95);
    check("R5 raw write to fp zero slot", rd_a_data, 64'h7FF8_0000_0000_0001);
    write(95, 64'h1234_5678_9ABC_DEF0, 1'b0);
    read2(95, 100);
    check("R4 later value write dropped", rd_a_data, 64'h7FF8_0000_0000_0001);
    write(100, 64'hFFFF_FFFF_FFFF_FFFE, 1'b0);
    write(70,  64'h8000_0000_0000_0001, 1'b1);
    read2(100, 70);
    check("R11 full width fp value", rd_a_data, 64'hFFFF_FFFF_FFFF_FFFE);
    check("R5 raw write other fp slot", rd_b_data, 64'h8000_0000_0000_0001);
  endtask

  task automatic t_timing();
    read2(10, 10);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 8'd10; wr_data = 64'h0A0A_0A0A_0A0A_0A0A; wr_raw = 1'b0;
    #1;
    check("R7 old value before edge", rd_a_data, '0);
    @(posedge clk);
    #1;
    check("R7 new value after edge", rd_b_data, 64'h0A0A_0A0A_0A0A_0A0A);
    @(negedge clk);
    wr_en = 1'b0; wr_idx = '0;
  endtask

  task automatic t_out_of_range();
    read2(200, 5);
    check("R9 oor read returns zero", rd_a_data, '0);
    check("R9 oor read raises error", DATA_W'(idx_err), 64'd1);
    read2(5, 128);
    check("R9 index 128 raises error", DATA_W'(idx_err), 64'd1);
    write(127, 64'h0000_0000_0000_0127, 1'b0);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 8'd200; wr_data = 64'h5555_5555_5555_5555;
    rd_a_idx = 8'd72; rd_b_idx = 8'd127;
    #1;
    check("R9 oor write raises error", DATA_W'(idx_err), 64'd1);
    @(negedge clk);
    wr_en = 1'b0; wr_idx = '0;
    read2(72, 127);
    check("R9 oor write left alias untouched", rd_a_data, '0);
    check("R2 last fp index 127", rd_b_data, 64'h127);
  endtask

  task automatic t_idle();
    @(negedge clk);
    wr_en = 1'b0; wr_idx = 8'd250; wr_data = 64'hFEED_FEED_FEED_FEED;
    read2(12, 12);
    check("R10 idle write idx no error", DATA_W'(idx_err), '0);
    @(negedge clk);
    wr_idx = 8'd12;
    @(negedge clk);
    read2(12, 12);
    check("R10 no write with wr_en low", rd_a_data, '0);
    wr_idx = '0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_raw = 1'b0; wr_idx = '0; wr_data = '0;
    rd_a_idx = '0; rd_b_idx = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_banks();
    t_int_zero();
    t_fp_zero_raw();
    t_timing();
    t_out_of_range();
    t_idle();
    finish_run();
  end
endmodule